// File: doc/BRIEF.md
# Dual-Bank Boot Watchdog and Reset Supervisor

This block watches a system boot from one of two flash banks. Each time the power-good input rises, a countdown timer is loaded from a 4-bit timeout setting and counts down on a one-millisecond tick. A second failure test counts the rising edges of power-good. Booting has failed when that count goes past a programmable limit. When either test finds a failure, the block sets a sticky flag. In auto mode it also drives an active-low system reset as one or two pulses of fixed width and spacing, and it swaps the bank select to the other flash.

The surrounding chip provides several things: the mode and enable settings, the timeout and limit values, the one/two-pulse choice, a permission bit for bank swapping, and write-1-to-clear strobes for the flags. The block returns the reset line, the current bank, the enable state, both flags and the present edge count. The one-millisecond tick comes from a shared prescaler. Parameters count the timer length, pulse width and gap in ticks, so a bench can shorten them.

Top module: `boot_supervisor`

## Requirements
- R1: With `ms_tick` high every cycle, `rst_out_n` first goes low exactly (timeout_sel+1)*UNIT_TICKS+3 clock cycles after `pwr_good` is driven high. The 3 cycles are two synchroniser stages plus the timer load.
- R2: While synchronised power-good is low, the countdown is stopped and cleared. A later rise reloads the full timeout, and a drop before expiry produces no reset.
- R3: On each power-good rise, `wdt_en` takes the value of `auto_mode`. A host write (`en_wr`) overrides it in the same cycle. While `wdt_en` is 0, the countdown does not advance.
- R4: Each reset pulse holds `rst_out_n` low for LOW_TICKS ticks. With `two_pulse`=1, a second low pulse of the same width follows after GAP_TICKS ticks high. With `two_pulse`=0, only one pulse is produced.
- R5: Every power-good rise increments `edge_count`. The rise that takes the count above `edge_limit` is a failure and returns `edge_count` to 0. With limit 2, the third rise fails.
- R6: A host write of enable = 0 clears `edge_count` to 0 on the next cycle.
- R7: `flag_clr` bit 0 clears `wdt_flag` and bit 1 clears `edge_flag`. Each flag is set by its own failure type and stays set until cleared. A set in the same cycle wins over a clear.
- R8: In auto mode, a failure starts a reset sequence. It toggles `bank_sel` only when `swap_allow` is 1. With `swap_allow`=0, the reset is still issued and the bank stays where it is.
- R9: In manual mode (`auto_mode`=0), a failure sets its flag, issues no reset and leaves `bank_sel` unchanged.
- R10: A failure that arrives while a reset sequence is running is dropped entirely: no flag, no bank change and no extra pulse.
- R11: After reset, `rst_out_n`=1, `bank_sel`=BANK_RESET (0), `wdt_en`=0, both flags are 0 and `edge_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-millisecond time-base strobe |
| pwr_good | input | 1 | Asynchronous power-good level |
| auto_mode | input | 1 | 1 = auto (failover active), 0 = manual |
| en_wr | input | 1 | Host write strobe for the watchdog enable |
| en_wdata | input | 1 | Enable value written by the host |
| timeout_sel | input | SEL_W | Timeout code, (value+1) time units |
| edge_limit | input | LIMIT_W | Power-good rise limit |
| two_pulse | input | 1 | 1 = two reset pulses, 0 = one |
| swap_allow | input | 1 | Permits the bank toggle on failure |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 timer flag, bit 1 edge flag |
| rst_out_n | output | 1 | Active-low system reset |
| bank_sel | output | 1 | Current boot bank |
| wdt_en | output | 1 | Current watchdog enable |
| wdt_flag | output | 1 | Sticky timer-expired flag |
| edge_flag | output | 1 | Sticky edge-limit flag |
| edge_count | output | LIMIT_W+1 | Power-good rises counted so far |

## Verification
The hardest case to reach is a second failure that lands inside a running reset sequence. The stimulus sets the edge limit to 0, so the first power-good rise fails at once and starts a two-pulse sequence. That same rise also loads a timer shorter than the whole sequence. The timer therefore expires while the reset is still busy. The bench then confirms that only the two expected pulses occur, that the timer flag stays clear and that the bank toggled only once. A scoreboard records the expected pulse widths and gaps, and a monitor measures every low pulse on the reset line against them.

// File: rtl/bootsup_pkg.sv
package bootsup_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW1 = 2'd1,
        PH_GAP  = 2'd2,
        PH_LOW2 = 2'd3
    } rst_phase_e;

    localparam int FLAG_TMR  = 0;
    localparam int FLAG_EDGE = 1;
    localparam int FLAG_N    = 2;

endpackage

// File: rtl/pg_edge_tracker.sv
module pg_edge_tracker #(
    parameter int SYNC_STAGES = 2,
    parameter int LIMIT_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_async,
    input  logic               cnt_clear,
    input  logic [LIMIT_W-1:0] limit,
    output logic               pg_level,
    output logic               pg_rise,
    output logic               over_limit,
    output logic [LIMIT_W:0]   count_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [LIMIT_W:0]       count;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [LIMIT_W:0] bump;

    always_comb begin
        trk_d      = trk_q;
        over_limit = 1'b0;
        trk_d.sync = {trk_q.sync[SYNC_STAGES-2:0], pg_async};
        pg_level   = trk_q.sync[SYNC_STAGES-1];
        pg_rise    = pg_level & ~trk_q.prev;
        trk_d.prev = pg_level;
        bump       = trk_q.count + (LIMIT_W+1)'(1);
        if (cnt_clear) begin
            trk_d.count = '0;
        end else if (pg_rise) begin
            if (bump > {1'b0, limit}) begin
                over_limit  = 1'b1;
                trk_d.count = '0;
            end else begin
                trk_d.count = bump;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign count_o = trk_q.count;

    assert_clear_on_disable_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (count_o == '0)
    ) else $error("edge count not cleared after disable");

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int UNIT_TICKS = 1000,
    parameter int SEL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pg_level,
    input  logic             pg_rise,
    input  logic             auto_mode,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic [SEL_W-1:0] sel,
    output logic             en_o,
    output logic             expire_o
);

    localparam int MAX_LOAD = (1 << SEL_W) * UNIT_TICKS;
    localparam int CNT_W    = $clog2(MAX_LOAD + 1);

    typedef struct packed {
        logic             en;
        logic             run;
        logic [CNT_W-1:0] cnt;
    } wdt_t;

    wdt_t wdt_d, wdt_q;
    logic [CNT_W-1:0] load;

    always_comb begin
        wdt_d    = wdt_q;
        expire_o = 1'b0;
        load     = (CNT_W'(sel) + CNT_W'(1)) * CNT_W'(UNIT_TICKS);
        if (pg_rise) wdt_d.en = auto_mode;
        if (en_wr)   wdt_d.en = en_wdata;
        if (!pg_level) begin
            wdt_d.run = 1'b0;
            wdt_d.cnt = '0;
        end else if (pg_rise) begin
            wdt_d.run = 1'b1;
            wdt_d.cnt = load;
        end else if (wdt_q.run && wdt_q.en && tick) begin
            if (wdt_q.cnt == CNT_W'(1)) begin
                expire_o  = 1'b1;
                wdt_d.run = 1'b0;
                wdt_d.cnt = '0;
            end else begin
                wdt_d.cnt = wdt_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_q <= '0;
        else        wdt_q <= wdt_d;
    end

    assign en_o = wdt_q.en;

    assert_stop_when_low_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !pg_level |=> !expire_o
    ) else $error("timer expired right after power-good low");

    assert_en_follows_mode_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (pg_rise && !en_wr) |=> (en_o == $past(auto_mode))
    ) else $error("enable did not take mode on rise");

endmodule

// File: rtl/rst_pulse_seq.sv
module rst_pulse_seq
    import bootsup_pkg::*;
#(
    parameter int LOW_TICKS = 200,
    parameter int GAP_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start_i,
    input  logic two_i,
    output logic rst_n_o,
    output logic busy_o
);

    localparam int MAXT  = (LOW_TICKS > GAP_TICKS) ? LOW_TICKS : GAP_TICKS;
    localparam int CNT_W = $clog2(MAXT + 1);

    typedef struct packed {
        rst_phase_e       phase;
        logic             two;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last;

    always_comb begin
        seq_d = seq_q;
        last  = tick && (seq_q.cnt == CNT_W'(1));
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_LOW1;
                    seq_d.two   = two_i;
                    seq_d.cnt   = CNT_W'(LOW_TICKS);
                end
            end
            PH_LOW1: begin
                if (last) begin
                    if (seq_q.two) begin
                        seq_d.phase = PH_GAP;
                        seq_d.cnt   = CNT_W'(GAP_TICKS);
                    end else begin
                        seq_d.phase = PH_IDLE;
                        seq_d.cnt   = '0;
                    end
                end else if (tick) begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_GAP: begin
                if (last) begin
                    seq_d.phase = PH_LOW2;
                    seq_d.cnt   = CNT_W'(LOW_TICKS);
                end else if (tick) begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (last) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.cnt   = '0;
                end else if (tick) begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, two: 1'b0, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign rst_n_o = !((seq_q.phase == PH_LOW1) || (seq_q.phase == PH_LOW2));
    assign busy_o  = (seq_q.phase != PH_IDLE);

    assert_low_lasts_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        ((LOW_TICKS > 1) && $fell(rst_n_o)) |=> !rst_n_o
    ) else $error("reset pulse shorter than two cycles");

    assert_no_restart_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i
    ) else $error("sequence restarted while busy");

endmodule

// File: rtl/boot_supervisor.sv
module boot_supervisor
    import bootsup_pkg::*;
#(
    parameter int   UNIT_TICKS  = 1000,
    parameter int   LOW_TICKS   = 200,
    parameter int   GAP_TICKS   = 1000,
    parameter int   SYNC_STAGES = 2,
    parameter int   SEL_W       = 4,
    parameter int   LIMIT_W     = 3,
    parameter logic BANK_RESET  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ms_tick,
    input  logic               pwr_good,
    input  logic               auto_mode,
    input  logic               en_wr,
    input  logic               en_wdata,
    input  logic [SEL_W-1:0]   timeout_sel,
    input  logic [LIMIT_W-1:0] edge_limit,
    input  logic               two_pulse,
    input  logic               swap_allow,
    input  logic [1:0]         flag_clr,
    output logic               rst_out_n,
    output logic               bank_sel,
    output logic               wdt_en,
    output logic               wdt_flag,
    output logic               edge_flag,
    output logic [LIMIT_W:0]   edge_count
);

    typedef struct packed {
        logic              bank;
        logic [FLAG_N-1:0] flags;
    } sup_t;

    sup_t sup_d, sup_q;

    logic pg_level, pg_rise, over_limit, expire, busy;
    logic cnt_clear, accept, start;

    assign cnt_clear = en_wr & ~en_wdata;

    pg_edge_tracker #(
        .SYNC_STAGES (SYNC_STAGES),
        .LIMIT_W     (LIMIT_W)
    ) u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .pg_async   (pwr_good),
        .cnt_clear  (cnt_clear),
        .limit      (edge_limit),
        .pg_level   (pg_level),
        .pg_rise    (pg_rise),
        .over_limit (over_limit),
        .count_o    (edge_count)
    );

    wdt_countdown #(
        .UNIT_TICKS (UNIT_TICKS),
        .SEL_W      (SEL_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ms_tick),
        .pg_level  (pg_level),
        .pg_rise   (pg_rise),
        .auto_mode (auto_mode),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .sel       (timeout_sel),
        .en_o      (wdt_en),
        .expire_o  (expire)
    );

    rst_pulse_seq #(
        .LOW_TICKS (LOW_TICKS),
        .GAP_TICKS (GAP_TICKS)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (ms_tick),
        .start_i (start),
        .two_i   (two_pulse),
        .rst_n_o (rst_out_n),
        .busy_o  (busy)
    );

    always_comb begin
        sup_d  = sup_q;
        accept = (expire | over_limit) & ~busy;
        start  = accept & auto_mode;
        for (int i = 0; i < FLAG_N; i++) begin
            if (flag_clr[i]) sup_d.flags[i] = 1'b0;
        end
        if (accept && expire)     sup_d.flags[FLAG_TMR]  = 1'b1;
        if (accept && over_limit) sup_d.flags[FLAG_EDGE] = 1'b1;
        if (start && swap_allow)  sup_d.bank = ~sup_q.bank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sup_q <= '{bank: BANK_RESET, flags: '0};
        else        sup_q <= sup_d;
    end

    assign bank_sel  = sup_q.bank;
    assign wdt_flag  = sup_q.flags[FLAG_TMR];
    assign edge_flag = sup_q.flags[FLAG_EDGE];

    assert_bank_moves_with_reset_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bank_sel != $past(bank_sel)) |-> (!rst_out_n && $past(rst_out_n))
    ) else $error("bank changed without a new reset sequence");

    assert_manual_no_reset_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> $past(auto_mode)
    ) else $error("reset issued in manual mode");

    assert_flag_sticky_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wdt_flag && !flag_clr[FLAG_TMR]) |=> wdt_flag
    ) else $error("timer flag dropped without clear");

endmodule

// File: tb/tb_boot_supervisor.sv
module tb_boot_supervisor;

    localparam int UT  = 8;
    localparam int LOW = 3;
    localparam int GAP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b1;
    logic       pwr_good = 1'b0;
    logic       auto_mode = 1'b1;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic [3:0] timeout_sel = 4'd9;
    logic [2:0] edge_limit = 3'd4;
    logic       two_pulse = 1'b0;
    logic       swap_allow = 1'b1;
    logic [1:0] flag_clr = 2'b00;
    logic       rst_out_n, bank_sel, wdt_en, wdt_flag, edge_flag;
    logic [3:0] edge_count;

    int checks = 0;
    int errors = 0;
    bit exp_bank = 1'b0;

    typedef struct {
        int    low;
        int    gap;
        string req;
    } pulse_t;
    pulse_t exp_q[$];

    always #10 clk = ~clk;

    boot_supervisor #(
        .UNIT_TICKS (UT),
        .LOW_TICKS  (LOW),
        .GAP_TICKS  (GAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_good(pwr_good),
        .auto_mode(auto_mode), .en_wr(en_wr), .en_wdata(en_wdata),
        .timeout_sel(timeout_sel), .edge_limit(edge_limit),
        .two_pulse(two_pulse), .swap_allow(swap_allow), .flag_clr(flag_clr),
        .rst_out_n(rst_out_n), .bank_sel(bank_sel), .wdt_en(wdt_en),
        .wdt_flag(wdt_flag), .edge_flag(edge_flag), .edge_count(edge_count)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic push(int low, int gap, string req);
        pulse_t p;
        p.low = low; p.gap = gap; p.req = req;
        exp_q.push_back(p);
    endtask

    task automatic pg_set(logic v);
        @(negedge clk);
        pwr_good = v;
    endtask

    task automatic clear_flags(logic [1:0] v);
        @(negedge clk); flag_clr = v;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    task automatic host_en(logic v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic time_to_reset(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (rst_out_n && n < 2000);
    endtask

    task automatic wait_idle();
        cycles(40);
    endtask

    // monitor: measures every low pulse and the high gap before it
    initial begin
        int  low_len = 0;
        int  high_len = 0;
        int  gap_seen = 0;
        bit  prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev = 1'b1;
            end else if (!rst_out_n) begin
                if (prev) begin
                    gap_seen = high_len;
                    low_len  = 0;
                end
                low_len++;
                prev = 1'b0;
            end else begin
                if (!prev) begin
                    if (exp_q.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R9/R10: actual unexpected pulse width %0d expected none", low_len);
                    end else begin
                        pulse_t p;
                        p = exp_q.pop_front();
                        chk({p.req, " pulse width"}, low_len, p.low);
                        if (p.gap >= 0) chk({p.req, " gap"}, gap_seen, p.gap);
                    end
                    high_len = 0;
                end
                high_len++;
                prev = 1'b1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        int n;
        cycles(3);
        // R11 reset state
        chk("R11 rst_out_n", rst_out_n, 1);
        chk("R11 bank", bank_sel, 0);
        chk("R11 wdt_en", wdt_en, 0);
        chk("R11 flags", {wdt_flag, edge_flag}, 0);
        chk("R11 count", edge_count, 0);
        rst_n = 1'b1;
        cycles(2);

        // T1: R1 single pulse, auto mode, bank swap
        push(LOW, -1, "R4");
        pg_set(1'b1);
        time_to_reset(n);
        chk("R1 latency sel=9", n, 10 * UT + 3);
        chk("R3 enable after auto rise", wdt_en, 1);
        wait_idle();
        exp_bank = ~exp_bank;
        chk("R8 bank toggled", bank_sel, exp_bank);
        chk("R7 wdt flag set", wdt_flag, 1);
        chk("R7 edge flag idle", edge_flag, 0);
        clear_flags(2'b01);
        chk("R7 wdt flag cleared", wdt_flag, 0);

        // T2: R2 drop before expiry, then two-pulse restart
        pg_set(1'b0);
        cycles(5);
        pg_set(1'b1);
        cycles(40);
        pg_set(1'b0);
        cycles(200);
        chk("R2 no reset after early drop", rst_out_n, 1);
        chk("R2 bank unchanged", bank_sel, exp_bank);
        chk("R2 no flag", wdt_flag, 0);
        timeout_sel = 4'd1;
        two_pulse   = 1'b1;
        push(LOW, -1, "R4");
        push(LOW, GAP, "R4");
        pg_set(1'b1);
        time_to_reset(n);
        chk("R1 latency sel=1", n, 2 * UT + 3);
        wait_idle();
        exp_bank = ~exp_bank;
        chk("R8 bank toggled back", bank_sel, exp_bank);
        clear_flags(2'b11);

        // T3: R6 count cleared on host disable
        chk("R5 count after three rises", edge_count, 3);
        host_en(1'b0);
        chk("R6 count cleared", edge_count, 0);
        chk("R3 host disable", wdt_en, 0);

        // T4: R5 third rise exceeds limit 2
        pg_set(1'b0);
        timeout_sel = 4'd9;
        two_pulse   = 1'b0;
        edge_limit  = 3'd2;
        cycles(5);
        for (int i = 0; i < 2; i++) begin
            pg_set(1'b1); cycles(6);
            pg_set(1'b0); cycles(6);
        end
        chk("R5 count two", edge_count, 2);
        chk("R5 no flag yet", edge_flag, 0);
        push(LOW, -1, "R5");
        pg_set(1'b1); cycles(6);
        pg_set(1'b0);
        wait_idle();
        exp_bank = ~exp_bank;
        chk("R5 edge flag", edge_flag, 1);
        chk("R5 count wraps", edge_count, 0);
        chk("R5 bank toggled", bank_sel, exp_bank);
        clear_flags(2'b10);
        chk("R7 edge flag cleared", edge_flag, 0);

        // T5: R9 manual mode
        auto_mode   = 1'b0;
        edge_limit  = 3'd0;
        timeout_sel = 4'd0;
        pg_set(1'b1);
        cycles(5);
        chk("R3 manual rise disables", wdt_en, 0);
        chk("R9 edge flag manual", edge_flag, 1);
        cycles(100);
        chk("R3 paused timer no flag", wdt_flag, 0);
        host_en(1'b1);
        cycles(30);
        chk("R9 wdt flag manual", wdt_flag, 1);
        chk("R9 reset stays high", rst_out_n, 1);
        chk("R9 bank unchanged", bank_sel, exp_bank);
        clear_flags(2'b11);

        // T6: R10 timer expiry during a running sequence
        pg_set(1'b0);
        auto_mode = 1'b1;
        two_pulse = 1'b1;
        cycles(5);
        push(LOW, -1, "R10");
        push(LOW, GAP, "R10");
        pg_set(1'b1);
        wait_idle();
        exp_bank = ~exp_bank;
        chk("R10 edge flag", edge_flag, 1);
        chk("R10 dropped expiry", wdt_flag, 0);
        chk("R10 single toggle", bank_sel, exp_bank);
        clear_flags(2'b11);

        // T7: R8 swap not allowed
        pg_set(1'b0);
        edge_limit = 3'd7;
        two_pulse  = 1'b0;
        swap_allow = 1'b0;
        cycles(5);
        push(LOW, -1, "R8");
        pg_set(1'b1);
        time_to_reset(n);
        chk("R1 latency sel=0", n, UT + 3);
        wait_idle();
        chk("R8 reset without swap", bank_sel, exp_bank);
        chk("R8 flag set", wdt_flag, 1);

        cycles(10);
        chk("R4 all expected pulses seen", exp_q.size(), 0);
        report();
    end

endmodule